// File: doc/BRIEF.md
# Instruction Cache with Early-Restart Line Refill

A direct-mapped instruction cache that sits between an instruction fetch unit and a simple memory read port. The fetch side presents a word address and a sequential hint on a valid/ready handshake and receives one 32-bit instruction word a cycle after the handshake completes. The memory side takes one 64-bit row address per beat and returns rows in the order they were requested.

On a miss the cache fetches the row holding the wanted word first, then the remaining rows of the line in ascending order, wrapping past the end of the line. A per-row valid vector covers only the line in flight, so the stalled request is released as soon as its row lands, and later requests to rows that already arrived are answered while the rest of the line is still streaming in. A request flagged as sequential that asks for the upper half of the doubleword fetched for the previous request is served from the held read data with no array read. Back-pressure rules: a requester keeps `req_valid`, `req_addr` and `req_seq` stable until `req_ready` is seen high at a rising edge; the response stays unchanged while `rsp_valid` is high and `rsp_ready` is low, and no new request is taken in that time. `req_ready` is combinational from the presented address and the cache state.

Top module: `icache_early_restart`

## Requirements
- R1: After reset `rsp_valid` and `mem_req_valid` are low and no line is valid, so the first request to any line gets `req_ready` low until memory has delivered data.
- R2: A request to a fully present line is accepted in the cycle it is presented (`req_ready` high), `rsp_valid` rises after that edge with the word, and no memory request is issued.
- R3: Word address layout: bit 0 picks the half of a 64-bit row (0 = bits 31:0, 1 = bits 63:32), bits 3:1 pick the row, bits 8:4 the line, bits 29:9 form the tag; the memory row address is word address bits 29:1.
- R4: A refill issues exactly eight row addresses of the missed line, starting at the missed row and counting up modulo eight.
- R5: A missed request is accepted once the first returned beat (its own row) has been written, without waiting for the rest of the line.
- R6: While a line refills, a request to one of its rows that has arrived is accepted at once; a request to a row still pending is held until that row arrives.
- R7: A miss to a different line during a refill is held until the current refill has written all eight rows, and only then starts its own refill.
- R8: The cache is direct mapped: a miss on a line index holding another tag replaces that line, and the old address then misses again.
- R9: A request with `req_seq` high, address bit 0 set, and the same row address as the previous accepted request (which had bit 0 clear) is accepted at once with the upper half of that row and no memory traffic.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_insn` stay unchanged and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Fetch request taken at this edge |
| req_addr | input | 30 | Word address of the instruction |
| req_seq | input | 1 | Request follows the previous one sequentially |
| rsp_valid | output | 1 | Instruction word present |
| rsp_ready | input | 1 | Requester takes the instruction word |
| rsp_insn | output | 32 | Instruction word |
| mem_req_valid | output | 1 | Row read request present |
| mem_req_ready | input | 1 | Memory takes the row read request |
| mem_req_addr | output | 29 | Row address |
| mem_rsp_valid | input | 1 | Returned row present, in request order |
| mem_rsp_data | input | 64 | Returned row data |

## Verification
The bench counts returned memory beats at the moment each request is accepted, so a cache that restarts late, fetches row 0 first, or blocks hits until the line completes shows up as a wrong beat count rather than only as a slower run. It logs the row addresses the refill issues to catch a wrap that overflows into the next line or starts at the wrong row. A miss to a second line is placed in the middle of a refill, where a design that drops or corrupts the running refill would return bad data or a wrong beat count. Stalls with a pending request expose outputs that drift or requests that are silently consumed, and eviction by a conflicting tag catches a stale hit.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;

  localparam int unsigned WORDS_PER_ROW = 2;
endpackage

// File: rtl/icache_data_ram.sv
module icache_data_ram #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Read data changes only on an enabled read; otherwise it is held.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int IDX_BITS = 5,
  parameter int TAG_W    = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_BITS-1:0] lk_idx,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic                lk_hit,
  input  logic                inval_en,
  input  logic [IDX_BITS-1:0] inval_idx,
  input  logic                commit_en,
  input  logic [IDX_BITS-1:0] commit_idx,
  input  logic [TAG_W-1:0]    commit_tag
);
  localparam int LINES = 1 << IDX_BITS;

  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] line_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_ok <= '0;
    end else begin
      if (inval_en)  line_ok[inval_idx]  <= 1'b0;
      if (commit_en) line_ok[commit_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit_en) tags[commit_idx] <= commit_tag;
  end

  assign lk_hit = line_ok[lk_idx] && (tags[lk_idx] == lk_tag);

  // A line is dropped when its refill starts and set when it ends: never both.
  assert_no_dual_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(inval_en && commit_en));
endmodule

// File: rtl/icache_refill.sv
module icache_refill
  import icache_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int IDX_BITS = 5,
  parameter int TAG_W    = 21
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_en,
  input  logic [TAG_W-1:0]             start_tag,
  input  logic [IDX_BITS-1:0]          start_idx,
  input  logic [ROW_BITS-1:0]          start_row,
  input  logic [TAG_W-1:0]             lk_tag,
  input  logic [IDX_BITS-1:0]          lk_idx,
  input  logic [ROW_BITS-1:0]          lk_row,
  output logic                         lk_hit,
  output logic                         busy,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [TAG_W+IDX_BITS+ROW_BITS-1:0] mem_req_addr,
  input  logic                         mem_rsp_valid,
  output logic                         wr_en,
  output logic [IDX_BITS+ROW_BITS-1:0] wr_addr,
  output logic                         commit_en,
  output logic [IDX_BITS-1:0]          fill_idx,
  output logic [TAG_W-1:0]             fill_tag
);
  localparam int ROWS = 1 << ROW_BITS;

  fill_state_e          state;
  logic [ROW_BITS-1:0]  first_row;
  logic [ROW_BITS:0]    issue_cnt;
  logic [ROW_BITS-1:0]  recv_cnt;
  logic [ROWS-1:0]      row_here;
  logic [ROW_BITS-1:0]  issue_row;
  logic [ROW_BITS-1:0]  land_row;
  logic                 last_beat;

  assign busy      = (state == FILL_BUSY);
  assign issue_row = first_row + issue_cnt[ROW_BITS-1:0];
  assign land_row  = first_row + recv_cnt;
  assign last_beat = (recv_cnt == ROW_BITS'(ROWS - 1));

  assign mem_req_valid = busy && !issue_cnt[ROW_BITS];
  assign mem_req_addr  = {fill_tag, fill_idx, issue_row};
  assign wr_en         = busy && mem_rsp_valid;
  assign wr_addr       = {fill_idx, land_row};
  assign commit_en     = wr_en && last_beat;

  assign lk_hit = busy && (lk_idx == fill_idx) && (lk_tag == fill_tag) && row_here[lk_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= FILL_IDLE;
      first_row <= '0;
      issue_cnt <= '0;
      recv_cnt  <= '0;
      row_here  <= '0;
      fill_idx  <= '0;
      fill_tag  <= '0;
    end else begin
      case (state)
        FILL_IDLE: begin
          if (start_en) begin
            state     <= FILL_BUSY;
            first_row <= start_row;
            fill_idx  <= start_idx;
            fill_tag  <= start_tag;
            issue_cnt <= '0;
            recv_cnt  <= '0;
            row_here  <= '0;
          end
        end
        FILL_BUSY: begin
          if (mem_req_valid && mem_req_ready) issue_cnt <= issue_cnt + 1'b1;
          if (mem_rsp_valid) begin
            row_here[land_row] <= 1'b1;
            recv_cnt           <= recv_cnt + 1'b1;
            if (last_beat) state <= FILL_IDLE;
          end
        end
        default: state <= FILL_IDLE;
      endcase
    end
  end

  // The line is committed only with every other row already landed and all issued.
  assert_commit_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> ($countones(row_here) == ROWS - 1) && issue_cnt[ROW_BITS]);

  // Returned rows only ever answer requests already issued for this refill.
  assert_rsp_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> busy && ({1'b0, recv_cnt} < issue_cnt));

  // A refill ends only on a returned beat.
  assert_end_on_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_rsp_valid));
endmodule

// File: rtl/icache_early_restart.sv
module icache_early_restart #(
  parameter int WADDR_W = 30,
  parameter int WORD_W  = 32,
  parameter int ROWS_PER_LINE = 8,
  parameter int NUM_LINES = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [WADDR_W-1:0]  req_addr,
  input  logic                req_seq,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_insn,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [WADDR_W-2:0]  mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [2*WORD_W-1:0] mem_rsp_data
);
  localparam int ROW_W    = 2 * WORD_W;
  localparam int ROW_BITS = $clog2(ROWS_PER_LINE);
  localparam int IDX_BITS = $clog2(NUM_LINES);
  localparam int RADDR_W  = WADDR_W - 1;
  localparam int TAG_W    = RADDR_W - ROW_BITS - IDX_BITS;

  // Address decode
  logic                 a_half;
  logic [ROW_BITS-1:0]  a_row;
  logic [IDX_BITS-1:0]  a_idx;
  logic [TAG_W-1:0]     a_tag;
  logic [RADDR_W-1:0]   a_raddr;

  assign a_half  = req_addr[0];
  assign a_row   = req_addr[1 +: ROW_BITS];
  assign a_idx   = req_addr[1 + ROW_BITS +: IDX_BITS];
  assign a_tag   = req_addr[WADDR_W-1 -: TAG_W];
  assign a_raddr = req_addr[WADDR_W-1:1];

  logic line_hit, part_hit, hit_any, busy;
  logic seq_ok, can_take, accept, ram_re, miss_start;
  logic commit_en, wr_en;
  logic [IDX_BITS+ROW_BITS-1:0] wr_addr;
  logic [IDX_BITS-1:0] fill_idx;
  logic [TAG_W-1:0]    fill_tag;
  logic [ROW_W-1:0]    ram_q;

  logic               half_q;
  logic               last_low;
  logic [RADDR_W-1:0] last_raddr;

  assign hit_any    = line_hit || part_hit;
  assign seq_ok     = req_seq && a_half && last_low && (a_raddr == last_raddr);
  assign can_take   = !rsp_valid || rsp_ready;
  assign req_ready  = can_take && (seq_ok || hit_any);
  assign accept     = req_valid && req_ready;
  assign ram_re     = accept && !seq_ok;
  assign miss_start = req_valid && !seq_ok && !hit_any && !busy;

  icache_tag_store #(
    .IDX_BITS (IDX_BITS),
    .TAG_W    (TAG_W)
  ) tags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_idx     (a_idx),
    .lk_tag     (a_tag),
    .lk_hit     (line_hit),
    .inval_en   (miss_start),
    .inval_idx  (a_idx),
    .commit_en  (commit_en),
    .commit_idx (fill_idx),
    .commit_tag (fill_tag)
  );

  icache_refill #(
    .ROW_BITS (ROW_BITS),
    .IDX_BITS (IDX_BITS),
    .TAG_W    (TAG_W)
  ) fill_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_en      (miss_start),
    .start_tag     (a_tag),
    .start_idx     (a_idx),
    .start_row     (a_row),
    .lk_tag        (a_tag),
    .lk_idx        (a_idx),
    .lk_row        (a_row),
    .lk_hit        (part_hit),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .commit_en     (commit_en),
    .fill_idx      (fill_idx),
    .fill_tag      (fill_tag)
  );

  icache_data_ram #(
    .AW (IDX_BITS + ROW_BITS),
    .DW (ROW_W)
  ) data_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (mem_rsp_data),
    .rd_en   (ram_re),
    .rd_addr ({a_idx, a_row}),
    .rd_data (ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      half_q     <= 1'b0;
      last_low   <= 1'b0;
      last_raddr <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      half_q     <= a_half;
      last_low   <= !a_half;
      last_raddr <= a_raddr;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assign rsp_insn = half_q ? ram_q[ROW_W-1:WORD_W] : ram_q[WORD_W-1:0];

  // The committed line was invalidated at refill start, so the two lookups never agree.
  assert_hit_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_hit && part_hit));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_insn)));
endmodule

// File: tb/icache_early_restart_tb_top.sv
`timescale 1ns/1ps
module icache_early_restart_tb_top;
  localparam int WA = 30;
  localparam int RA = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [WA-1:0] req_addr = '0;
  logic          req_seq = 1'b0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_insn;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic [RA-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [63:0]   mem_rsp_data = '0;

  always #2 clk = ~clk;

  icache_early_restart dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_seq(req_seq),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_insn(rsp_insn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int total = 0;
  int bad = 0;
  bit summary_done = 0;

  function automatic logic [31:0] mw(input logic [WA-1:0] w);
    return {w[13:0], w[29:12]} ^ 32'hC3A5_1E0F;
  endfunction

  function automatic logic [63:0] row_data(input logic [RA-1:0] r);
    return {mw({r, 1'b1}), mw({r, 1'b0})};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Memory model: in-order, one beat per four cycles, answered no earlier than one cycle later.
  logic [RA-1:0] q [16];
  int qh = 0, qt = 0, gap = 0, beats = 0, nlog = 0;
  logic [RA-1:0] issue_log [64];

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        mem_rsp_valid = 1'b0;
        if (gap > 0) gap--;
        else if (qt != qh) begin
          mem_rsp_data  = row_data(q[qh % 16]);
          qh++;
          mem_rsp_valid = 1'b1;
          gap = 3;
          beats++;
        end
        if (mem_req_valid) begin
          q[qt % 16] = mem_req_addr;
          qt++;
          if (nlog < 64) issue_log[nlog] = mem_req_addr;
          nlog++;
        end
      end
    end
  end

  task automatic fetch(input logic [WA-1:0] a, input bit s,
                       output logic [31:0] word, output int waits, output int beats_at);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_seq = s;
    #1;
    waits = 0;
    while (!req_ready && waits < 3000) begin
      @(negedge clk); #1; waits++;
    end
    beats_at = beats;
    @(negedge clk);
    req_valid = 1'b0; req_seq = 1'b0;
    #1;
    word = rsp_insn;
    chk(rsp_valid == 1'b1, "R2", "rsp_valid after accept", {31'b0, rsp_valid}, 32'd1);
  endtask

  localparam int NV = 10;
  localparam logic [WA-1:0] V_ADDR [NV] = '{30'h4031, 30'h8085, 30'hC114, 30'hC115, 30'hC11E,
                                             30'h14030, 30'h403A, 30'h403B, 30'h8080, 30'h14031};
  // 0 = present line, 1 = miss, 2 = sequential reuse
  localparam logic [1:0] V_KIND [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd1, 2'd2, 2'd0, 2'd1};

  initial begin
    logic [31:0] w, prev;
    int wt, ba, base;
    localparam logic [WA-1:0] A = 30'h403A;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'd0);
    req_valid = 1'b1; req_addr = A; #0.5;
    chk(req_ready == 1'b0, "R1", "cold request not ready", {31'b0, req_ready}, 32'd0);
    req_valid = 1'b0;

    // R5 early restart at the missed row
    base = beats;
    fetch(A, 1'b0, w, wt, ba);
    chk(w == mw(A), "R3", "row5 low word", w, mw(A));
    chk(wt > 0, "R1", "cold miss waits", wt, 32'd1);
    chk(ba - base == 1, "R5", "beats at critical accept", ba - base, 32'd1);

    // R6 pending row waits for its beat, landed row served at once
    fetch(30'h403E, 1'b0, w, wt, ba);
    chk(ba - base == 3, "R6", "beats at row7 accept", ba - base, 32'd3);
    chk(w == mw(30'h403E), "R6", "row7 data", w, mw(30'h403E));
    fetch(A, 1'b0, w, wt, ba);
    chk(wt == 0, "R6", "arrived row immediate", wt, 32'd0);

    // R9 sequential reuse of the upper half
    fetch(30'h403B, 1'b1, w, wt, ba);
    chk(wt == 0, "R9", "seq immediate", wt, 32'd0);
    chk(w == mw(30'h403B), "R9", "seq upper half", w, mw(30'h403B));

    // R7 other-line miss during refill waits for completion
    fetch(30'h8080, 1'b0, w, wt, ba);
    chk(ba - base == 9, "R7", "beats at second line accept", ba - base, 32'd9);
    chk(w == mw(30'h8080), "R7", "second line data", w, mw(30'h8080));

    // R4 wrapped row order of the first refill
    for (int i = 0; i < 8; i++) begin
      logic [RA-1:0] e;
      e = {A[29:4], 3'((5 + i) % 8)};
      chk(issue_log[i] == e, "R4", $sformatf("row address %0d", i), {3'b0, issue_log[i]}, {3'b0, e});
    end
    repeat (40) @(negedge clk);
    chk(nlog == 16, "R4", "rows issued for two refills", nlog, 32'd16);

    // R2 hit on complete line, no memory traffic
    base = beats;
    fetch(30'h4034, 1'b0, w, wt, ba);
    chk(wt == 0 && beats == base && nlog == 16, "R2", "hit without traffic", wt, 32'd0);
    chk(w == mw(30'h4034), "R2", "hit data", w, mw(30'h4034));

    // Vector table
    for (int v = 0; v < NV; v++) begin
      int b0, n0;
      b0 = beats; n0 = nlog;
      fetch(V_ADDR[v], V_KIND[v] == 2'd2, w, wt, ba);
      chk(w == mw(V_ADDR[v]), "R3", $sformatf("vector %0d data", v), w, mw(V_ADDR[v]));
      if (V_KIND[v] == 2'd1) begin
        chk(wt > 0 && ba - b0 >= 1, "R8", $sformatf("vector %0d misses", v), wt, 32'd1);
        repeat (40) @(negedge clk);
      end else begin
        chk(wt == 0 && nlog == n0, V_KIND[v] == 2'd2 ? "R9" : "R2",
            $sformatf("vector %0d immediate", v), wt, 32'd0);
      end
    end

    // R10 stall hold with a pending request
    fetch(30'h8081, 1'b0, prev, wt, ba);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 30'h8082;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(rsp_valid == 1'b1 && rsp_insn == prev, "R10", "output held", rsp_insn, prev);
      chk(req_ready == 1'b0, "R10", "no accept while stalled", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1; #1;
    chk(req_ready == 1'b1, "R10", "accept after release", {31'b0, req_ready}, 32'd1);
    @(negedge clk); req_valid = 1'b0; #1;
    chk(rsp_insn == mw(30'h8082), "R10", "data after release", rsp_insn, mw(30'h8082));

    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule